// File: doc/BRIEF.md
# Serial EEPROM I2C Target Engine

This block is the bus-facing engine of a small serial memory. It acts as a target on a two-wire I2C bus. It watches SCL and SDA, which have already been synchronized to the system clock. It pulls SDA low through a single enable output and never drives it high. The memory behind it is a byte array built from flip-flops. A control byte selects the device and the transfer direction. A write-type frame carries a two-byte word address and at most one data byte. A read-type frame streams bytes out of the array for as long as the master keeps acknowledging.

A single address counter serves every transfer. Loading a word address sets it. Each byte that is written or read then advances it by one. A read that carries no address therefore continues from the last access, and a random read is an address-only write frame followed by a repeated Start. A byte write is committed when the master sends Stop. An internal write cycle then runs for a fixed number of clocks. During that cycle the engine refuses its control byte, so the master can poll until the engine answers again.

Top module: `ee_i2c_target`

## Requirements
- R1: A control byte carries the 7-bit device address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). When bits 7:1 equal `dev_addr_i` and no write cycle is running, the engine acknowledges by holding SDA low for the whole ninth SCL high phase.
- R2: When the address in a control byte does not match, the engine gives no acknowledge. It then leaves SDA released for every later bit until the next Start.
- R3: In a write frame the word address follows the control byte as two bytes, high byte first. Each byte is acknowledged. Bit 7 of the high byte and any address bits above the array width are ignored. The counter takes the new value after the low byte, and a repeated Start keeps that value.
- R4: In a write frame only the first data byte is acknowledged. It is stored at the counter's address when the master sends Stop, and the counter moves to that address plus one. Any further data byte in the same frame gets no acknowledge and is not stored.
- R5: After a Stop that commits a byte, the engine acknowledges no control byte for WR_CYCLES clocks. After that window it acknowledges again.
- R6: In a read frame the engine acknowledges the control byte. It then drives the byte at the counter onto SDA, most significant bit first, one bit per SCL low phase, and advances the counter.
- R7: If the master acknowledges a read byte, the engine sends the byte at the next address. The counter rolls over from the top of the array to address 0.
- R8: If the master does not acknowledge a read byte, the engine releases SDA and drives nothing until the next Start.
- R9: A read frame with no preceding address returns the byte at n+1, where n is the address of the last byte read or written.
- R10: A Start or Stop seen at any bit position returns the engine to control-byte reception or to idle, and it leaves the counter unchanged. A byte pending in a write frame that ends with a repeated Start instead of Stop is dropped.
- R11: SDA is released after reset. The SDA enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level as seen on the bus |
| dev_addr_i | input | 7 | Device address matched against control bytes |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Some rules are checked on every cycle:
- The SDA enable stays stable through each SCL high phase.
- The engine is silent whenever it sits idle.
- No control byte is acknowledged while the write timer is running.
- The array is written only on a Stop, and each write starts the timer.
- Each byte loaded for transmit advances the counter by exactly one.

Other behaviour shows only in the bench's frame sequences:
- The data values returned.
- How the counter carries from writes into current-address reads.
- Rollover at the top of the array.
- Dropping of a second data byte, and of a write cut off by a repeated Start.
- An aborted address that leaves the counter untouched.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTRL,
      ST_CACK,
      ST_AHI,
      ST_AHACK,
      ST_ALO,
      ST_ALACK,
      ST_WDAT,
      ST_WACK,
      ST_TX,
      ST_RACK
   } state_t;

endpackage

// File: rtl/ee_bus_cond.sv
module ee_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic rise_o,
   output logic fall_o,
   output logic start_o,
   output logic stop_o
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign rise_o  = scl_i & ~scl_q;
   assign fall_o  = ~scl_i & scl_q;
   assign start_o = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
   parameter int CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left <= '0;
      end else if (start_i) begin
         left <= CW'(CYCLES);
      end else if (left != '0) begin
         left <= left - CW'(1);
      end
   end

   assign busy_o = (left != '0);

endmodule

// File: rtl/ee_byte_mem.sv
module ee_byte_mem #(
   parameter int DEPTH     = 1024,
   parameter int AW        = $clog2(DEPTH),
   parameter bit RESET_EN  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [7:0]    wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [7:0]    rdata_o
);

   logic [7:0] cells [DEPTH];

   generate
      if (RESET_EN) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
            end else if (we_i) begin
               cells[waddr_i] <= wdata_i;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we_i) cells[waddr_i] <= wdata_i;
         end
      end
   endgenerate

   assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/ee_i2c_target.sv
module ee_i2c_target #(
   parameter int DEPTH     = 1024,
   parameter int WR_CYCLES = 5000,
   parameter bit MEM_RESET = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [6:0] dev_addr_i,
   output logic       sda_oe_o
);
   import ee_i2c_pkg::*;

   localparam int AW = $clog2(DEPTH);
   localparam int HW = (AW > 8) ? AW - 8 : 1;
   localparam logic [AW-1:0] CNT_ONE = AW'(1);

   generate
      if (DEPTH < 2 || DEPTH > 32768 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two between 2 and 32768");
      end
      if (WR_CYCLES < 1) begin : g_bad_wr
         $error("WR_CYCLES must be at least 1");
      end
   endgenerate

   logic          rise_ev, fall_ev, start_ev, stop_ev;
   logic          busy, mem_we, tx_load, ahi_cap, byte_done, is_rx, ctrl_ok;
   state_t        st;
   logic [3:0]    bitn;
   logic [7:0]    rxsh, txsh, pend_data, mem_rdata;
   logic          rd_mode, mack, pend, oe;
   logic [AW-1:0] cnt, pend_addr, addr_ld;

   ee_bus_cond u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_i),
      .sda_i   (sda_i),
      .rise_o  (rise_ev),
      .fall_o  (fall_ev),
      .start_o (start_ev),
      .stop_o  (stop_ev)
   );

   ee_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (mem_we),
      .busy_o  (busy)
   );

   ee_byte_mem #(.DEPTH(DEPTH), .AW(AW), .RESET_EN(MEM_RESET)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mem_we),
      .waddr_i (pend_addr),
      .wdata_i (pend_data),
      .raddr_i (cnt),
      .rdata_o (mem_rdata)
   );

   assign is_rx     = (st == ST_CTRL) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WDAT);
   assign byte_done = is_rx && fall_ev && (bitn == 4'd8);
   assign ctrl_ok   = (rxsh[7:1] == dev_addr_i) && !busy;
   assign tx_load   = fall_ev && (((st == ST_CACK) && rd_mode) || ((st == ST_RACK) && mack));
   assign mem_we    = stop_ev && pend;
   assign ahi_cap   = byte_done && (st == ST_AHI);

   // high address bits are kept only when the array needs them
   generate
      if (AW > 8) begin : g_hi
         logic [HW-1:0] ahi;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ahi <= '0;
            else if (ahi_cap) ahi <= rxsh[HW-1:0];
         end
         assign addr_ld = {ahi, rxsh};
      end else begin : g_lo
         logic unused_cap;
         assign unused_cap = ahi_cap;
         assign addr_ld    = rxsh[AW-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         bitn      <= 4'd0;
         rxsh      <= 8'h00;
         txsh      <= 8'h00;
         oe        <= 1'b0;
         rd_mode   <= 1'b0;
         mack      <= 1'b0;
         pend      <= 1'b0;
         pend_addr <= '0;
         pend_data <= 8'h00;
         cnt       <= '0;
      end else if (start_ev) begin
         st   <= ST_CTRL;
         bitn <= 4'd0;
         oe   <= 1'b0;
         pend <= 1'b0;
      end else if (stop_ev) begin
         st   <= ST_IDLE;
         oe   <= 1'b0;
         pend <= 1'b0;
      end else if (tx_load) begin
         txsh <= mem_rdata;
         oe   <= ~mem_rdata[7];
         cnt  <= cnt + CNT_ONE;
         bitn <= 4'd0;
         st   <= ST_TX;
      end else begin
         unique case (st)
            ST_CTRL, ST_AHI, ST_ALO, ST_WDAT: begin
               if (rise_ev && (bitn != 4'd8)) begin
                  rxsh <= {rxsh[6:0], sda_i};
                  bitn <= bitn + 4'd1;
               end else if (byte_done) begin
                  bitn <= 4'd0;
                  if (st == ST_CTRL) begin
                     if (ctrl_ok) begin
                        oe      <= 1'b1;
                        rd_mode <= rxsh[0];
                        st      <= ST_CACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else if (st == ST_AHI) begin
                     oe <= 1'b1;
                     st <= ST_AHACK;
                  end else if (st == ST_ALO) begin
                     cnt <= addr_ld;
                     oe  <= 1'b1;
                     st  <= ST_ALACK;
                  end else if (!pend) begin
                     pend      <= 1'b1;
                     pend_addr <= cnt;
                     pend_data <= rxsh;
                     cnt       <= cnt + CNT_ONE;
                     oe        <= 1'b1;
                     st        <= ST_WACK;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            ST_CACK: if (fall_ev) begin
               oe   <= 1'b0;
               bitn <= 4'd0;
               st   <= ST_AHI;
            end
            ST_AHACK: if (fall_ev) begin
               oe <= 1'b0;
               st <= ST_ALO;
            end
            ST_ALACK, ST_WACK: if (fall_ev) begin
               oe <= 1'b0;
               st <= ST_WDAT;
            end
            ST_TX: if (fall_ev) begin
               if (bitn == 4'd7) begin
                  oe <= 1'b0;
                  st <= ST_RACK;
               end else begin
                  txsh <= {txsh[6:0], 1'b0};
                  oe   <= ~txsh[6];
                  bitn <= bitn + 4'd1;
               end
            end
            ST_RACK: begin
               if (rise_ev) begin
                  mack <= ~sda_i;
               end else if (fall_ev) begin
                  oe <= 1'b0;
                  st <= ST_IDLE;
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = oe;

endmodule

// File: rtl/ee_i2c_target_chk.sv
module ee_i2c_target_chk #(
   parameter int AW = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                scl_i,
   input logic                sda_oe_o,
   input ee_i2c_pkg::state_t  st,
   input logic                busy,
   input logic                tx_load,
   input logic [AW-1:0]       cnt,
   input logic                mem_we,
   input logic                stop_ev
);
   import ee_i2c_pkg::*;

   localparam logic [AW-1:0] STEP = AW'(1);

   // R11
   oe_hold_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

   // R5
   no_ack_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CACK) |-> !busy);

   // R8
   idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe_o);

   // R7
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> (cnt == $past(cnt) + STEP));

   // R4
   write_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> stop_ev);

   // R5
   write_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> busy);

endmodule

bind ee_i2c_target ee_i2c_target_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .sda_oe_o (sda_oe_o),
   .st       (st),
   .busy     (busy),
   .tx_load  (tx_load),
   .cnt      (cnt),
   .mem_we   (mem_we),
   .stop_ev  (stop_ev)
);

// File: tb/ee_i2c_target_bench.sv
`timescale 1ns/1ps
module ee_i2c_target_bench;

   localparam int DEPTH = 1024;
   localparam int WR    = 300;
   localparam int Q     = 4;
   localparam logic [6:0] DEV = 7'h50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_bus;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   logic [7:0] ref_mem [DEPTH];
   int         ref_cnt = 0;

   always #2 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   ee_i2c_target #(.DEPTH(DEPTH), .WR_CYCLES(WR)) u_ee_i2c_target (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_bus),
      .dev_addr_i (DEV),
      .sda_oe_o   (sda_oe)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic hold();
      repeat (Q) @(negedge clk);
   endtask

   // one SCL period; the expected enable is compared on every clock of the high phase
   task automatic xfer_bit(input logic drv, input logic exp_oe, output logic seen, output bit mism);
      sda_m = drv;
      hold();
      scl_m = 1'b1;
      mism = 1'b0;
      for (int i = 0; i < Q; i++) begin
         @(negedge clk);
         if (sda_oe !== exp_oe) mism = 1'b1;
      end
      seen = sda_bus;
      scl_m = 1'b0;
      hold();
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hold();
      scl_m = 1'b1; hold();
      sda_m = 1'b0; hold();
      scl_m = 1'b0; hold();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hold();
      scl_m = 1'b1; hold();
      sda_m = 1'b1; hold();
   endtask

   task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
      logic seen;
      bit   m;
      bit   anym = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         xfer_bit(b[i], 1'b0, seen, m);
         anym |= m;
      end
      chk(!anym, req, "enable during received byte", int'(anym), 0);
      xfer_bit(1'b1, exp_ack, seen, m);
      chk(!m && (seen == ~exp_ack), req, "ack bit", int'({m, seen}), int'({1'b0, ~exp_ack}));
   endtask

   task automatic recv_byte(input logic [7:0] exp, input logic give_ack, input string req);
      logic [7:0] got;
      logic seen;
      bit   m;
      bit   anym = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         xfer_bit(1'b1, ~exp[i], seen, m);
         got[i] = seen;
         anym |= m;
      end
      chk((got == exp) && !anym, req, "read byte", int'(got), int'(exp));
      xfer_bit(~give_ack, 1'b0, seen, m);
      chk(!m, req, "released during master ack", int'(m), 0);
   endtask

   task automatic settle();
      repeat (WR + 40) @(negedge clk);
   endtask

   task automatic wr_byte(input logic [15:0] a, input logic [7:0] d, input string req);
      int pa;
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R1");
      send_byte(a[15:8], 1'b1, req);
      send_byte(a[7:0], 1'b1, req);
      ref_cnt = int'(a) % DEPTH;
      send_byte(d, 1'b1, req);
      pa = ref_cnt;
      ref_cnt = (ref_cnt + 1) % DEPTH;
      bus_stop();
      ref_mem[pa] = d;
   endtask

   task automatic rd_body(input int n, input string req);
      send_byte({DEV, 1'b1}, 1'b1, "R1");
      for (int k = 0; k < n; k++) begin
         recv_byte(ref_mem[ref_cnt], (k != n - 1), req);
         ref_cnt = (ref_cnt + 1) % DEPTH;
      end
   endtask

   task automatic cur_read(input int n, input string req);
      bus_start();
      rd_body(n, req);
      bus_stop();
   endtask

   task automatic rnd_read(input logic [15:0] a, input int n, input string req);
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R1");
      send_byte(a[15:8], 1'b1, "R3");
      send_byte(a[7:0], 1'b1, "R3");
      ref_cnt = int'(a) % DEPTH;
      bus_start();
      rd_body(n, req);
      bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic seen;
      bit   m;
      bit   anym;
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      hold();
      // R11: released after reset
      chk(sda_oe == 1'b0, "R11", "enable after reset", int'(sda_oe), 0);

      // R9: counter starts at 0 after reset
      cur_read(1, "R9");

      // R3: bit 15 and bits above the array width are ignored
      wr_byte(16'h8013, 8'hE1, "R3"); settle();
      wr_byte(16'h0010, 8'hA5, "R4"); settle();
      wr_byte(16'h0011, 8'h3C, "R4"); settle();
      wr_byte(16'h0014, 8'h6B, "R4"); settle();
      wr_byte(16'h0022, 8'h4E, "R4"); settle();
      wr_byte(16'h7C12, 8'h77, "R3"); settle();

      // R9: continues after the last write
      cur_read(1, "R9");
      // R7: sequential read with master acks
      rnd_read(16'h0010, 3, "R7");
      // R9: continues after the last read
      cur_read(1, "R9");

      // R2: wrong device address, then silence for the next byte
      bus_start();
      send_byte({DEV ^ 7'h01, 1'b1}, 1'b0, "R2");
      send_byte(8'h00, 1'b0, "R2");
      bus_stop();
      cur_read(1, "R2");

      // R5: poll during the write cycle, then after it
      wr_byte(16'h03FF, 8'h5A, "R4");
      bus_start();
      send_byte({DEV, 1'b0}, 1'b0, "R5");
      bus_stop();
      settle();
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R5");
      bus_stop();
      wr_byte(16'h0000, 8'hC3, "R4"); settle();
      // R7: rollover from the top address to 0
      rnd_read(16'h03FF, 2, "R7");

      // R4: a second data byte is refused and not stored
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R1");
      send_byte(8'h00, 1'b1, "R3");
      send_byte(8'h20, 1'b1, "R3");
      send_byte(8'hD1, 1'b1, "R4");
      send_byte(8'hD2, 1'b0, "R4");
      bus_stop();
      ref_mem[32'h20] = 8'hD1;
      settle();
      rnd_read(16'h0020, 2, "R4");

      // R10: Stop in the middle of the low address byte leaves the counter
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R1");
      send_byte(8'h01, 1'b1, "R10");
      anym = 1'b0;
      for (int i = 0; i < 3; i++) begin
         xfer_bit(i[0], 1'b0, seen, m);
         anym |= m;
      end
      chk(!anym, "R10", "enable during cut byte", int'(anym), 0);
      bus_stop();
      cur_read(1, "R10");

      // R10: write cut off by a repeated Start is dropped
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R1");
      send_byte(8'h00, 1'b1, "R3");
      send_byte(8'h30, 1'b1, "R3");
      ref_cnt = 32'h30;
      send_byte(8'h99, 1'b1, "R4");
      ref_cnt = 32'h31;
      bus_start();
      rd_body(1, "R10");
      bus_stop();
      rnd_read(16'h0030, 1, "R10");

      // R6 and R8: read, master NACK, then the engine stays silent
      bus_start();
      rd_body(1, "R6");
      anym = 1'b0;
      for (int i = 0; i < 8; i++) begin
         xfer_bit(1'b1, 1'b0, seen, m);
         anym |= m;
      end
      chk(!anym, "R8", "enable after master NACK", int'(anym), 0);
      bus_stop();
      cur_read(1, "R9");

      hold();
      finish_run();
   end

endmodule